// File: doc/BRIEF.md
# Latchable Wired-OR Bus Transceiver

This block sits between a local logic-side port and a shared open-drain backplane. It has nine data lanes. On the outbound side, the local value either goes straight to the bus or passes through a transparent-low holding stage. It is then inverted and driven onto the backplane as a pull-low or release per lane. A two-input enable gates every bus driver at once. On the inbound side, the backplane level is inverted and presented on the local port behind a tri-state enable. Here the tri-state is modelled as a data vector plus a drive-valid flag.

A competitor flag supports arbitration over the wired bus. The block first loads its competing value into the holding stage. It then asserts an active-low request. From then on, the flag stays released for as long as the resolved bus level equals the level the held value would produce. When another agent pulls down a lane that this block leaves released, the flag pulls low. Several instances on one net therefore find out which of them lost.

The bus is modelled digitally. A driver output of 1 means release and 0 means pull low. The net is the AND of all drivers and the pull-up.

Top module: `wor_bus_xcvr`

## Requirements
- R1: When `rx_oe` is 1, `a_out` equals the bitwise complement of `b_in` and `a_drive` is 1. When `rx_oe` is 0, `a_drive` is 0 and `a_out` is all zeros.
- R2: With `route_bypass` = 1, the bus pattern follows the local input with no storage: an enabled `b_rel` equals `~a_in` in the same cycle.
- R3: With `route_bypass` = 0 and `hold_n` = 0, the holding stage is transparent: an enabled `b_rel` equals `~a_in` in the same cycle.
- R4: The holding stage loads `a_in` at each rising `clk` edge while `hold_n` is 0. While `hold_n` is 1 it keeps its value, and in held routing `b_rel` ignores changes on `a_in`.
- R5: Bus drivers are active only when `tx_en_hi` = 1 and `tx_en_lo_n` = 0. For every other combination, `b_rel` is all ones (all lanes released).
- R6: A synchronous reset on `rst` clears the held value to zero, so held routing with enabled drivers releases every lane (`b_rel` all ones).
- R7: While `arb_req_n` is 1, `cmp_rel` is 1 (released), whatever the bus holds.
- R8: While `arb_req_n` is 0, `cmp_rel` is 1 exactly when `b_in` equals the complement of the held value. Any lane difference gives 0.
- R9: With two instances on one AND-resolved net, the instance whose held value pulls down a superset of the other's lanes keeps `cmp_rel` = 1. The other instance sees `cmp_rel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding stage |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 9 | Local-side outbound data |
| a_out | output | 9 | Local-side inbound data (inverted bus) |
| a_drive | output | 1 | Local-side tri-state drive valid |
| rx_oe | input | 1 | Local-side output enable, active high |
| route_bypass | input | 1 | 1 = direct path, 0 = via holding stage |
| hold_n | input | 1 | 0 = holding stage transparent/loading, 1 = hold |
| tx_en_hi | input | 1 | Bus driver enable, must be 1 |
| tx_en_lo_n | input | 1 | Bus driver enable, must be 0 |
| b_in | input | 9 | Resolved backplane level |
| b_rel | output | 9 | Per-lane bus driver, 1 = release, 0 = pull low |
| arb_req_n | input | 1 | Arbitration request, active low |
| cmp_rel | output | 1 | Competitor flag, 1 = released/match, 0 = mismatch |

## Verification
The competitor compare and the outbound drive act in the same cycle on the same net. The value an instance puts on the bus feeds straight back into its own compare, along with every other agent's pull-downs. The bench loads two instances with overlapping values, requests arbitration on both, and then reads both flags on the resolved net. The winner must stay released and the loser must pull low. A further test makes the bench itself pull a single extra lane low. The flag must change on that lane alone, and a lane that is already low must leave it unchanged.

// File: rtl/wor_bus_xcvr_pkg.sv
package wor_bus_xcvr_pkg;

    typedef enum logic {
        ROUTE_HELD   = 1'b0,
        ROUTE_DIRECT = 1'b1
    } route_e;

    typedef struct packed {
        route_e route;
        logic   hold_n;
    } tx_ctrl_t;

    typedef struct packed {
        logic en_hi;
        logic en_lo_n;
    } drv_en_t;

    function automatic logic drivers_on(input drv_en_t e);
        return e.en_hi & ~e.en_lo_n;
    endfunction

endpackage

// File: rtl/wor_hold_stage.sv
module wor_hold_stage
    import wor_bus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  tx_ctrl_t         ctrl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] presented
);
    logic [WIDTH-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst)
            store_q <= '0;
        else if (!ctrl.hold_n)
            store_q <= din;
    end

    always_comb begin
        if (ctrl.route == ROUTE_DIRECT || !ctrl.hold_n)
            presented = din;
        else
            presented = store_q;
    end

    assign held = store_q;
endmodule

// File: rtl/wor_bus_drive.sv
module wor_bus_drive
    import wor_bus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  drv_en_t          en,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] rel
);
    logic on;
    assign on = drivers_on(en);

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        // a high local bit pulls the lane low; otherwise release
        assign rel[i] = on ? ~data[i] : 1'b1;
    end
endmodule

// File: rtl/wor_bus_recv.sv
module wor_bus_recv #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] bus,
    input  logic             oe,
    input  logic [WIDTH-1:0] held,
    input  logic             req_n,
    output logic [WIDTH-1:0] dout,
    output logic             drive,
    output logic             flag_rel
);
    logic [WIDTH-1:0] lane_diff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign dout[i]      = oe ? ~bus[i] : 1'b0;
        assign lane_diff[i] = bus[i] ^ ~held[i];
    end

    assign drive    = oe;
    assign flag_rel = req_n | ~(|lane_diff);
endmodule

// File: rtl/wor_bus_xcvr.sv
module wor_bus_xcvr
    import wor_bus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    input  logic             rx_oe,
    input  logic             route_bypass,
    input  logic             hold_n,
    input  logic             tx_en_hi,
    input  logic             tx_en_lo_n,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_rel,
    input  logic             arb_req_n,
    output logic             cmp_rel
);
    tx_ctrl_t         ctrl;
    drv_en_t          en;
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] presented;

    assign ctrl.route   = route_bypass ? ROUTE_DIRECT : ROUTE_HELD;
    assign ctrl.hold_n  = hold_n;
    assign en.en_hi     = tx_en_hi;
    assign en.en_lo_n   = tx_en_lo_n;

    wor_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .din       (a_in),
        .held      (held),
        .presented (presented)
    );

    wor_bus_drive #(.WIDTH(WIDTH)) u_drive (
        .en   (en),
        .data (presented),
        .rel  (b_rel)
    );

    wor_bus_recv #(.WIDTH(WIDTH)) u_recv (
        .bus      (b_in),
        .oe       (rx_oe),
        .held     (held),
        .req_n    (arb_req_n),
        .dout     (a_out),
        .drive    (a_drive),
        .flag_rel (cmp_rel)
    );
endmodule

// File: rtl/wor_bus_xcvr_chk.sv
module wor_bus_xcvr_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic             route_bypass,
    input logic             hold_n,
    input logic             tx_en_hi,
    input logic             tx_en_lo_n,
    input logic             arb_req_n,
    input logic [WIDTH-1:0] b_rel,
    input logic             cmp_rel
);
    logic on;
    assign on = tx_en_hi && !tx_en_lo_n;

    // R5
    drivers_off_release_chk: assert property (@(posedge clk) disable iff (rst)
        !on |-> b_rel == '1);

    // R7
    no_request_released_chk: assert property (@(posedge clk) disable iff (rst)
        arb_req_n |-> cmp_rel);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && hold_n && $past(hold_n) && !route_bypass && !$past(route_bypass)
         && on && $past(on)) |-> $stable(b_rel));

    // R6
    reset_release_chk: assert property (@(posedge clk)
        ($past(rst) && !rst && hold_n && !route_bypass && on) |-> b_rel == '1);

    // R2
    direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (route_bypass && on) |-> b_rel == ~a_in);
endmodule

bind wor_bus_xcvr wor_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .a_in         (a_in),
    .route_bypass (route_bypass),
    .hold_n       (hold_n),
    .tx_en_hi     (tx_en_hi),
    .tx_en_lo_n   (tx_en_lo_n),
    .arb_req_n    (arb_req_n),
    .b_rel        (b_rel),
    .cmp_rel      (cmp_rel)
);

// File: tb/tb_wor_bus_xcvr.sv
module tb_wor_bus_xcvr;
    localparam int W = 9;

    typedef struct packed {
        logic [W-1:0] a;
        logic         bypass;
        logic         hold_n;
        logic         en_hi;
        logic         en_lo_n;
        logic [W-1:0] exp_rel;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{9'h0A5, 1'b1, 1'b1, 1'b1, 1'b0, 9'h15A},  // R2
        '{9'h1FF, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000},  // R2
        '{9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 9'h1FF},  // R3
        '{9'h13C, 1'b0, 1'b0, 1'b1, 1'b0, 9'h0C3},  // R3
        '{9'h0FF, 1'b1, 1'b1, 1'b0, 1'b0, 9'h1FF},  // R5
        '{9'h0FF, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1FF},  // R5
        '{9'h0FF, 1'b1, 1'b1, 1'b1, 1'b0, 9'h100}   // R5
    };

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    // instance under test
    logic [W-1:0] a_in, a_out, b_rel;
    logic a_drive, rx_oe, route_bypass, hold_n, tx_en_hi, tx_en_lo_n, arb_req_n, cmp_rel;
    // second competitor
    logic [W-1:0] a2_in, a2_out, b2_rel;
    logic a2_drive, hold2_n, en2_hi, arb2_req_n, cmp2_rel;
    // bench pull-downs and resolved net
    logic [W-1:0] tb_rel;
    logic [W-1:0] bus;
    assign bus = b_rel & b2_rel & tb_rel;

    wor_bus_xcvr #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .rx_oe(rx_oe), .route_bypass(route_bypass), .hold_n(hold_n),
        .tx_en_hi(tx_en_hi), .tx_en_lo_n(tx_en_lo_n), .b_in(bus), .b_rel(b_rel),
        .arb_req_n(arb_req_n), .cmp_rel(cmp_rel)
    );

    wor_bus_xcvr #(.WIDTH(W)) dut2 (
        .clk(clk), .rst(rst), .a_in(a2_in), .a_out(a2_out), .a_drive(a2_drive),
        .rx_oe(1'b0), .route_bypass(1'b0), .hold_n(hold2_n),
        .tx_en_hi(en2_hi), .tx_en_lo_n(1'b0), .b_in(bus), .b_rel(b2_rel),
        .arb_req_n(arb2_req_n), .cmp_rel(cmp2_rel)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    task automatic check(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; a_in = '0; rx_oe = 1'b0; route_bypass = 1'b0; hold_n = 1'b1;
        tx_en_hi = 1'b1; tx_en_lo_n = 1'b0; arb_req_n = 1'b1;
        a2_in = '0; hold2_n = 1'b1; en2_hi = 1'b0; arb2_req_n = 1'b1; tb_rel = '1;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        #1;
        check("R6 reset releases all lanes", b_rel, 9'h1FF);
        check("R7 flag released at reset", {8'h0, cmp_rel}, 9'h001);

        // vector table
        for (int i = 0; i < NV; i++) begin
            a_in = VECS[i].a; route_bypass = VECS[i].bypass; hold_n = VECS[i].hold_n;
            tx_en_hi = VECS[i].en_hi; tx_en_lo_n = VECS[i].en_lo_n;
            #1;
            check($sformatf("R2 R3 R5 vector %0d", i), b_rel, VECS[i].exp_rel);
            step();
        end

        // R4 capture then hold
        route_bypass = 1'b0; tx_en_hi = 1'b1; tx_en_lo_n = 1'b0;
        hold_n = 1'b0; a_in = 9'h033;
        step();
        hold_n = 1'b1; a_in = 9'h1F0;
        #1;
        check("R4 held value after rise", b_rel, 9'h1CC);
        step();
        a_in = 9'h00F;
        #1;
        check("R4 input change ignored", b_rel, 9'h1CC);

        // R1 receive path
        tx_en_hi = 1'b0; tb_rel = 9'h0F0; rx_oe = 1'b1;
        #1;
        check("R1 inverted receive", a_out, 9'h10F);
        check("R1 drive valid", {8'h0, a_drive}, 9'h001);
        rx_oe = 1'b0;
        #1;
        check("R1 drive off", {8'h0, a_drive}, 9'h000);
        check("R1 data zero when off", a_out, 9'h000);

        // R8 single competitor, held 0x033 presents 0x1CC
        tx_en_hi = 1'b1; tb_rel = '1; arb_req_n = 1'b0;
        #1;
        check("R8 match", {8'h0, cmp_rel}, 9'h001);
        tb_rel = 9'h1FD;
        #1;
        check("R8 extra pull on low lane no effect", {8'h0, cmp_rel}, 9'h001);
        tb_rel = 9'h1FB;
        #1;
        check("R8 mismatch lane 2", {8'h0, cmp_rel}, 9'h000);
        arb_req_n = 1'b1;
        #1;
        check("R7 released without request", {8'h0, cmp_rel}, 9'h001);
        tb_rel = '1;

        // R9 two competitors: dut2 holds 0x037 (presents 0x1C8)
        a2_in = 9'h037; hold2_n = 1'b0;
        step();
        hold2_n = 1'b1; a2_in = '0; en2_hi = 1'b1;
        arb_req_n = 1'b0; arb2_req_n = 1'b0;
        #1;
        check("R9 resolved net", bus, 9'h1C8);
        check("R9 loser flag low", {8'h0, cmp_rel}, 9'h000);
        check("R9 winner flag high", {8'h0, cmp2_rel}, 9'h001);

        // R6 reset clears held data again
        arb_req_n = 1'b1; arb2_req_n = 1'b1; en2_hi = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        #1;
        check("R6 held cleared by reset", b_rel, 9'h1FF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule